// File: doc/BRIEF.md
# Indexed Configuration Register Space for a Multi-Function I/O Controller

This block is the chip-side configuration logic of a multi-function I/O controller. The host reaches it through a byte-wide bus on two adjacent I/O addresses, the key/index port and the data port. The register space stays locked until the host writes the unlock key 0x55 twice in a row to the key/index port. While the space is unlocked, a write to that port selects a register, and the data port reads or writes the selected register. A single 0xAA on the key/index port locks the space again.

Registers below index 0x30 are global: the device selector, the chip identity and a power summary. Registers at 0x30 and above are banked. The device selector picks one of nine per-device banks: floppy, IDE1, IDE2, parallel, serial1, serial2, RTC, keyboard and aux I/O. Each bank holds an activate flag, a 16-bit base address, interrupt selects and a DMA select. Every bank drives its values continuously to its device, so the device logic sees its configuration no matter which bank is currently selected.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, `cfg_open` is 0, `rdata` is 0xFF, every device is inactive, and all bank outputs and the floppy mode byte are zero.
- R2: Two consecutive writes of 0x55 to the key/index port (`port_sel`=0) open the space. A single 0x55 leaves it locked.
- R3: After a single 0x55, any write to either port other than 0x55 on the key/index port cancels the partial unlock. A further 0x55 then counts as a first key again.
- R4: While open, a write of 0xAA to the key/index port locks the space. `cfg_open` falls one cycle later and reads return 0xFF.
- R5: While locked, both ports read 0xFF and data-port writes change no register or output.
- R6: While open, a key/index port write loads the index, a key/index port read returns it, and data-port accesses target the indexed register.
- R7: Index 0x07 holds the device selector (low 4 bits, read back zero-extended). Values 0 to 8 pick a bank. Values 9 and above pick none: banked writes are dropped and banked reads return 0.
- R8: Index 0x20 reads 0x02 and index 0x21 reads the revision byte 0x01. Both are read-only.
- R9: In the selected bank, index 0x30 bit 0 is the activate flag, index 0x60 is base address bits 15:8 and index 0x61 is bits 7:0. Each value appears on that device's output lane.
- R10: Index 0x70 is the primary interrupt select (4 bits kept). Index 0x72 (4 bits) exists only in device 7. Index 0x74 (3-bit DMA select) exists only in devices 0 and 3. Where a register is absent, writes are ignored and reads return 0.
- R11: Index 0x22 is read-only. Bit n equals the activate flag of device n for n = 0..5, and bits 7:6 read 0.
- R12: Index 0x90 exists only in device 0. It is a full read/write byte, so a read-modify-write that sets bits 3:1 drives `fdd_mode` and raises `fdd_burst`.
- R13: A bank keeps all its values while a different device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| port_sel | input | 1 | 0 = key/index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the port chosen by port_sel |
| cfg_open | output | 1 | Configuration space unlocked |
| dev_active | output | 9 | Activate flag per device |
| dev_base | output | 144 | 16-bit base address per device, device n at bits 16n+15:16n |
| dev_irq | output | 36 | Primary interrupt select per device, 4 bits each |
| dev_irq2 | output | 36 | Secondary interrupt select per device (only device 7 nonzero) |
| dev_dma | output | 27 | DMA select per device, 3 bits each (only devices 0 and 3 nonzero) |
| fdd_mode | output | 8 | Floppy mode byte |
| fdd_burst | output | 1 | Floppy mode bits 3:1 all set |

## Verification
The bench targets the unlock sequence:
- A lone 0x55 must not open the space. A design that counted keys without requiring them back to back would let stray host traffic unlock it.
- A partial unlock interrupted by a write to the data port, or by a different byte on the key/index port, must not open the space. A design that failed to cancel would open on the third write.

The bench also writes through registers that are absent: 0x72 outside the keyboard bank, 0x74 outside the floppy and parallel banks, 0x90 outside bank 0, and a selector beyond the last device. A design with faulty decoding would show the value on another device's output lanes or read it back. After the space is locked, the bench writes to the data port and expects no output change. It also expects 0x22 to track only the low six activate flags. A design that mirrored all flags would show device 7 there.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   typedef enum logic [1:0] {LK_LOCKED = 2'd0, LK_HALF = 2'd1, LK_OPEN = 2'd2} lock_t;

   localparam logic [7:0] KEY_ENTER = 8'h55;
   localparam logic [7:0] KEY_EXIT  = 8'hAA;

   localparam logic [7:0] IX_LDN   = 8'h07;
   localparam logic [7:0] IX_ID    = 8'h20;
   localparam logic [7:0] IX_REV   = 8'h21;
   localparam logic [7:0] IX_PWR   = 8'h22;
   localparam logic [7:0] IX_BANK0 = 8'h30;
   localparam logic [7:0] IX_ACT   = 8'h30;
   localparam logic [7:0] IX_BHI   = 8'h60;
   localparam logic [7:0] IX_BLO   = 8'h61;
   localparam logic [7:0] IX_IRQA  = 8'h70;
   localparam logic [7:0] IX_IRQB  = 8'h72;
   localparam logic [7:0] IX_DMA   = 8'h74;
   localparam logic [7:0] IX_FMODE = 8'h90;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       port_sel,
   input  logic [7:0] wdata,
   output logic       open,
   output logic       idx_wr
);
   lock_t state, state_nx;
   logic  key_wr;

   assign key_wr = wr_en && !port_sel;

   always_comb begin
      state_nx = state;
      unique case (state)
         LK_LOCKED: if (key_wr && wdata == KEY_ENTER) state_nx = LK_HALF;
         LK_HALF: begin
            if (wr_en) state_nx = (key_wr && wdata == KEY_ENTER) ? LK_OPEN : LK_LOCKED;
         end
         LK_OPEN: if (key_wr && wdata == KEY_EXIT) state_nx = LK_LOCKED;
         default: state_nx = LK_LOCKED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= LK_LOCKED;
      else        state <= state_nx;
   end

   assign open   = (state == LK_OPEN);
   assign idx_wr = open && key_wr && wdata != KEY_EXIT;

   AST_SINGLE_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_LOCKED && key_wr && wdata == KEY_ENTER) |=> !open); // R2
   AST_PARTIAL_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_HALF && wr_en && !(key_wr && wdata == KEY_ENTER)) |=> state == LK_LOCKED); // R3
   AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (open && key_wr && wdata == KEY_EXIT) |=> !open); // R4
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
   import sio_cfg_pkg::*;
#(
   parameter int IRQ_W    = 4,
   parameter int DMA_W    = 3,
   parameter bit HAS_IRQ2 = 1'b0,
   parameter bit HAS_DMA  = 1'b0,
   parameter bit HAS_MODE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       idx,
   input  logic [7:0]       wdata,
   output logic             act,
   output logic [15:0]      base,
   output logic [IRQ_W-1:0] irq,
   output logic [IRQ_W-1:0] irq2,
   output logic [DMA_W-1:0] dma,
   output logic [7:0]       mode,
   output logic [7:0]       rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         base <= '0;
         irq  <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_ACT:  act        <= wdata[0];
            IX_BHI:  base[15:8] <= wdata;
            IX_BLO:  base[7:0]  <= wdata;
            IX_IRQA: irq        <= wdata[IRQ_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (HAS_IRQ2) begin : g_irq2
         logic [IRQ_W-1:0] irq2_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       irq2_q <= '0;
            else if (wr_en && idx == IX_IRQB) irq2_q <= wdata[IRQ_W-1:0];
         end
         assign irq2 = irq2_q;
      end else begin : g_no_irq2
         assign irq2 = '0;
      end

      if (HAS_DMA) begin : g_dma
         logic [DMA_W-1:0] dma_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                      dma_q <= '0;
            else if (wr_en && idx == IX_DMA) dma_q <= wdata[DMA_W-1:0];
         end
         assign dma = dma_q;
      end else begin : g_no_dma
         assign dma = '0;
      end

      if (HAS_MODE) begin : g_mode
         logic [7:0] mode_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                        mode_q <= '0;
            else if (wr_en && idx == IX_FMODE) mode_q <= wdata;
         end
         assign mode = mode_q;
      end else begin : g_no_mode
         assign mode = '0;
      end
   endgenerate

   always_comb begin
      case (idx)
         IX_ACT:   rdata = {7'b0, act};
         IX_BHI:   rdata = base[15:8];
         IX_BLO:   rdata = base[7:0];
         IX_IRQA:  rdata = 8'(irq);
         IX_IRQB:  rdata = 8'(irq2);
         IX_DMA:   rdata = 8'(dma);
         IX_FMODE: rdata = mode;
         default:  rdata = 8'h00;
      endcase
   end

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(act) && $stable(base) && $stable(irq) && $stable(irq2) && $stable(dma) && $stable(mode))); // R13
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int             NDEV     = 9,
   parameter int             IRQ_W    = 4,
   parameter int             DMA_W    = 3,
   parameter int             PWR_BITS = 6,
   parameter int             KBD_DEV  = 7,
   parameter int             FDC_DEV  = 0,
   parameter logic [NDEV-1:0] DMA_DEVS = 9'b0_0000_1001,
   parameter logic [7:0]     CHIP_ID  = 8'h02,
   parameter logic [7:0]     CHIP_REV = 8'h01
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    port_sel,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   output logic                    cfg_open,
   output logic [NDEV-1:0]         dev_active,
   output logic [NDEV*16-1:0]      dev_base,
   output logic [NDEV*IRQ_W-1:0]   dev_irq,
   output logic [NDEV*IRQ_W-1:0]   dev_irq2,
   output logic [NDEV*DMA_W-1:0]   dev_dma,
   output logic [7:0]              fdd_mode,
   output logic                    fdd_burst
);
   localparam int LDN_W = 4;

   generate
      if (NDEV < 1 || NDEV > (1 << LDN_W)) begin : g_bad_ndev
         $error("NDEV out of range for the device selector");
      end
      if (IRQ_W < 1 || IRQ_W > 8 || DMA_W < 1 || DMA_W > 8) begin : g_bad_w
         $error("select widths must be 1..8");
      end
      if (PWR_BITS > NDEV || PWR_BITS > 8 || KBD_DEV >= NDEV || FDC_DEV >= NDEV) begin : g_bad_map
         $error("device map parameters exceed NDEV");
      end
   endgenerate

   logic             idx_wr;
   logic [7:0]       index;
   logic [LDN_W-1:0] ldn;
   logic             data_wr;
   logic [7:0]       bank_rd [NDEV];
   logic [7:0]       bank_mode [NDEV];
   logic [7:0]       sel_rd;

   sio_cfg_unlock i_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .port_sel (port_sel),
      .wdata    (wdata),
      .open     (cfg_open),
      .idx_wr   (idx_wr)
   );

   assign data_wr = cfg_open && wr_en && port_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index <= '0;
         ldn   <= '0;
      end else begin
         if (idx_wr) index <= wdata;
         if (data_wr && index == IX_LDN) ldn <= wdata[LDN_W-1:0];
      end
   end

   generate
      for (genvar g = 0; g < NDEV; g++) begin : g_bank
         sio_cfg_bank #(
            .IRQ_W    (IRQ_W),
            .DMA_W    (DMA_W),
            .HAS_IRQ2 (g == KBD_DEV),
            .HAS_DMA  (DMA_DEVS[g]),
            .HAS_MODE (g == FDC_DEV)
         ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (data_wr && index >= IX_BANK0 && ldn == LDN_W'(g)),
            .idx   (index),
            .wdata (wdata),
            .act   (dev_active[g]),
            .base  (dev_base[g*16 +: 16]),
            .irq   (dev_irq[g*IRQ_W +: IRQ_W]),
            .irq2  (dev_irq2[g*IRQ_W +: IRQ_W]),
            .dma   (dev_dma[g*DMA_W +: DMA_W]),
            .mode  (bank_mode[g]),
            .rdata (bank_rd[g])
         );
      end
   endgenerate

   assign fdd_mode  = bank_mode[FDC_DEV];
   assign fdd_burst = &fdd_mode[3:1];

   always_comb begin
      sel_rd = 8'h00;
      for (int g = 0; g < NDEV; g++) begin
         if (ldn == LDN_W'(g)) sel_rd = bank_rd[g];
      end
   end

   always_comb begin
      rdata = 8'hFF;
      if (cfg_open) begin
         if (!port_sel) rdata = index;
         else if (index >= IX_BANK0) rdata = sel_rd;
         else begin
            case (index)
               IX_LDN:  rdata = 8'(ldn);
               IX_ID:   rdata = CHIP_ID;
               IX_REV:  rdata = CHIP_REV;
               IX_PWR:  rdata = 8'(dev_active[PWR_BITS-1:0]);
               default: rdata = 8'h00;
            endcase
         end
      end
   end

   AST_LOCKED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq) && $stable(fdd_mode))); // R5
   AST_SELECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_wr && index == IX_LDN) |=> $stable(ldn)); // R7
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
   localparam int ND = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             port_sel = 1'b0;
   logic [7:0]       wdata = 8'h00;
   logic [7:0]       rdata;
   logic             cfg_open;
   logic [ND-1:0]    dev_active;
   logic [ND*16-1:0] dev_base;
   logic [ND*4-1:0]  dev_irq;
   logic [ND*4-1:0]  dev_irq2;
   logic [ND*3-1:0]  dev_dma;
   logic [7:0]       fdd_mode;
   logic             fdd_burst;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_state = 0;   // 0 locked, 1 one key seen, 2 open
   int m_idx = 0;
   int m_ldn = 0;
   int m_act [ND];
   int m_base [ND];
   int m_irq [ND];
   int m_irq2 [ND];
   int m_dma [ND];
   int m_mode = 0;

   sio_cfg_port i_sio_cfg_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
      .rdata(rdata), .cfg_open(cfg_open), .dev_active(dev_active), .dev_base(dev_base),
      .dev_irq(dev_irq), .dev_irq2(dev_irq2), .dev_dma(dev_dma),
      .fdd_mode(fdd_mode), .fdd_burst(fdd_burst)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_read(input int p);
      if (m_state != 2) return 8'hFF;
      if (p == 0) return m_idx;
      if (m_idx >= 8'h30) begin
         if (m_ldn >= ND) return 0;
         case (m_idx)
            8'h30: return m_act[m_ldn];
            8'h60: return (m_base[m_ldn] >> 8) & 8'hFF;
            8'h61: return m_base[m_ldn] & 8'hFF;
            8'h70: return m_irq[m_ldn];
            8'h72: return m_irq2[m_ldn];
            8'h74: return m_dma[m_ldn];
            8'h90: return (m_ldn == 0) ? m_mode : 0;
            default: return 0;
         endcase
      end
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return 8'h02;
         8'h21: return 8'h01;
         8'h22: begin
            int v = 0;
            for (int d = 0; d < 6; d++) v = v | (m_act[d] << d);
            return v;
         end
         default: return 0;
      endcase
   endfunction

   task automatic model_write(input int p, input int d);
      if (p == 0) begin
         if (m_state == 0)      m_state = (d == 8'h55) ? 1 : 0;
         else if (m_state == 1) m_state = (d == 8'h55) ? 2 : 0;
         else if (d == 8'hAA)   m_state = 0;
         else                   m_idx = d;
      end else begin
         if (m_state == 1) m_state = 0;
         else if (m_state == 2) begin
            if (m_idx == 8'h07) m_ldn = d & 15;
            else if (m_idx >= 8'h30 && m_ldn < ND) begin
               case (m_idx)
                  8'h30: m_act[m_ldn] = d & 1;
                  8'h60: m_base[m_ldn] = (m_base[m_ldn] & 8'hFF) | (d << 8);
                  8'h61: m_base[m_ldn] = (m_base[m_ldn] & 16'hFF00) | d;
                  8'h70: m_irq[m_ldn] = d & 15;
                  8'h72: if (m_ldn == 7) m_irq2[m_ldn] = d & 15;
                  8'h74: if (m_ldn == 0 || m_ldn == 3) m_dma[m_ldn] = d & 7;
                  8'h90: if (m_ldn == 0) m_mode = d;
                  default: ;
               endcase
            end
         end
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(rdata == 8'(exp_read(int'(port_sel))), "MODEL rdata", rdata, exp_read(int'(port_sel)));
         check(cfg_open == (m_state == 2), "MODEL cfg_open", cfg_open, m_state == 2);
         for (int d = 0; d < ND; d++) begin
            check(dev_active[d] == m_act[d][0], "MODEL active", dev_active[d], m_act[d]);
            check(dev_base[d*16 +: 16] == 16'(m_base[d]), "MODEL base", dev_base[d*16 +: 16], m_base[d]);
            check(dev_irq[d*4 +: 4] == 4'(m_irq[d]), "MODEL irq", dev_irq[d*4 +: 4], m_irq[d]);
            check(dev_irq2[d*4 +: 4] == 4'(m_irq2[d]), "MODEL irq2", dev_irq2[d*4 +: 4], m_irq2[d]);
            check(dev_dma[d*3 +: 3] == 3'(m_dma[d]), "MODEL dma", dev_dma[d*3 +: 3], m_dma[d]);
         end
         check(fdd_mode == 8'(m_mode), "MODEL fdd_mode", fdd_mode, m_mode);
      end
   end

   task automatic wr(input int p, input int d);
      @(posedge clk); #1;
      port_sel = p[0]; wdata = 8'(d); wr_en = 1'b1;
      @(posedge clk); #1;
      model_write(p, d);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int p, input int exp, input string req);
      @(posedge clk); #1;
      port_sel = p[0]; wr_en = 1'b0;
      #5;
      check(rdata == 8'(exp), req, rdata, exp);
   endtask

   task automatic setreg(input int ix, input int d);
      wr(0, ix);
      wr(1, d);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      for (int d = 0; d < ND; d++) begin
         m_act[d] = 0; m_base[d] = 0; m_irq[d] = 0; m_irq2[d] = 0; m_dma[d] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(1, 8'hFF, "R1 locked data read");
      check(cfg_open == 1'b0, "R1 cfg_open", cfg_open, 0);
      check(dev_active == '0 && fdd_mode == 8'h00, "R1 outputs", dev_active, 0);

      // R2 a single key does not open
      wr(0, 8'h55);
      rd(1, 8'hFF, "R2 single key stays locked");
      wr(0, 8'h55);
      check(cfg_open == 1'b1, "R2 double key opens", cfg_open, 1);
      wr(0, 8'hAA);

      // R3 cancel by data write and by another key byte
      wr(0, 8'h55); wr(1, 8'h12); wr(0, 8'h55);
      rd(0, 8'hFF, "R3 data write cancels partial unlock");
      wr(0, 8'h00);
      wr(0, 8'h55); wr(0, 8'h56); wr(0, 8'h55);
      check(cfg_open == 1'b0, "R3 other byte cancels", cfg_open, 0);
      wr(0, 8'h55);
      check(cfg_open == 1'b1, "R3 restart opens", cfg_open, 1);

      // R6 index and data ports
      wr(0, 8'h07);
      rd(0, 8'h07, "R6 index readback");
      wr(1, 4);
      rd(1, 4, "R6 data port selector");

      // R9 serial1 bank
      setreg(8'h61, 8'hF8); setreg(8'h60, 8'h03);
      setreg(8'h70, 8'h04); setreg(8'h30, 8'h01);
      check(dev_base[4*16 +: 16] == 16'h03F8, "R9 base lane", dev_base[4*16 +: 16], 16'h03F8);
      check(dev_active[4] == 1'b1, "R9 activate lane", dev_active[4], 1);
      rd(1, 8'h01, "R9 activate readback");

      // R10 absent registers in bank 4
      setreg(8'h72, 8'h0C);
      rd(1, 0, "R10 irq2 absent in bank 4");
      setreg(8'h74, 8'h02);
      rd(1, 0, "R10 dma absent in bank 4");
      // keyboard bank
      setreg(8'h07, 7);
      setreg(8'h70, 8'hF1);
      rd(1, 8'h01, "R10 irq keeps 4 bits");
      setreg(8'h72, 8'h0C);
      check(dev_irq2[7*4 +: 4] == 4'hC, "R10 keyboard irq2 lane", dev_irq2[7*4 +: 4], 4'hC);
      // parallel bank DMA
      setreg(8'h07, 3);
      setreg(8'h74, 8'hFB);
      rd(1, 8'h03, "R10 dma keeps 3 bits");

      // R13 bank 4 held while others written
      check(dev_base[4*16 +: 16] == 16'h03F8 && dev_irq[4*4 +: 4] == 4'h4, "R13 bank 4 held",
            dev_base[4*16 +: 16], 16'h03F8);

      // R11 power summary
      setreg(8'h07, 7); setreg(8'h30, 8'h01);
      wr(0, 8'h22);
      rd(1, 8'h10, "R11 device 7 not in summary");
      setreg(8'h07, 0); setreg(8'h30, 8'h01);
      setreg(8'h22, 8'hFF);
      rd(1, 8'h11, "R11 summary read-only");

      // R12 floppy mode read-modify-write
      setreg(8'h90, 8'h40);
      rd(1, 8'h40, "R12 mode readback");
      wr(1, 8'h40 | 8'h0E);
      check(fdd_mode == 8'h4E && fdd_burst == 1'b1, "R12 burst after RMW", fdd_mode, 8'h4E);
      setreg(8'h07, 1); setreg(8'h90, 8'h33);
      rd(1, 0, "R12 mode absent in bank 1");

      // R8 identity
      setreg(8'h20, 8'h77);
      rd(1, 8'h02, "R8 id read-only");
      wr(0, 8'h21);
      rd(1, 8'h01, "R8 revision");

      // R7 selector beyond last device
      setreg(8'h07, 8'h0C);
      rd(1, 8'h0C, "R7 selector readback");
      setreg(8'h30, 8'h01);
      rd(1, 0, "R7 no bank selected");
      check(dev_active == 9'b0_1001_0001, "R7 no lane changed", dev_active, 9'h091);

      // R4 / R5 exit then locked writes ignored
      setreg(8'h07, 4);
      wr(0, 8'h30);
      wr(0, 8'hAA);
      rd(1, 8'hFF, "R4 closed after exit key");
      wr(1, 8'h00);
      check(dev_active[4] == 1'b1, "R5 locked write ignored", dev_active[4], 1);
      rd(0, 8'hFF, "R5 index port locked read");
      wr(0, 8'h55); wr(0, 8'h55);
      rd(0, 8'h30, "R5 index kept across lock");

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule